// File: doc/BRIEF.md
# SMBus Block-Access Register Slave

This block is a serial slave on an SMBus clock/data pair. It gives a bus host access to a small bank of 8-bit configuration registers. The rest of the chip sees the register contents as one flat parallel output. Both bus lines are sampled with the fast system clock through two-flop synchronizers. START, repeated START and STOP are detected on the synchronized lines, and edges are taken from them as well. The data line is modelled as open drain: the block only raises a drive-low enable.

Only two transactions are served, block write and block read.

- **Block write:** the host sends the matching 7-bit address with the direction bit low, then a command code of zero, then a byte count whose value is ignored, then data bytes. The data fills the registers starting at index 0.
- **Block read:** the host repeats the write-direction address and the zero command code, issues a repeated START, and sends the address again with the direction bit high. The slave then sends a byte count equal to the bank size, followed by the registers from index 0 upward, for as long as the host acknowledges.

Every accepted address resets the register pointer to zero. The pointer saturates at the bank size.

Top module: `smb_blk_slave`

## Requirements
- R1: An address byte whose upper seven bits equal DEV_ADDR is acknowledged (SDA held low in the ninth clock) for either direction bit (bit 0: 0 = write, 1 = read). Any other address is not acknowledged, and the rest of that transaction is ignored.
- R2: A command code of 0x00 is acknowledged. A nonzero command code is not acknowledged; the slave then acknowledges nothing and writes nothing until the next START or STOP.
- R3: In a block write, the byte after the command code is acknowledged whatever its value, and that value never limits or changes how many data bytes are stored.
- R4: Block write data bytes are each acknowledged and stored into registers 0, 1, 2 and onward in order. Register i appears on regs_o bits [8*i+7 : 8*i].
- R5: Data bytes written after the last register are still acknowledged but change no register.
- R6: In a block read, the first byte sent after the read address is the bank size NREG. Register contents from index 0 upward follow it, MSB first.
- R7: Read bytes requested after the last register are 0xFF.
- R8: When the host does not acknowledge a read byte, the slave stops driving SDA. It drives nothing more until the next START.
- R9: Each accepted address resets the register pointer to 0, so every transfer starts at register 0.
- R10: The slave only begins pulling SDA low while the synchronized SCL is low.
- R11: A STOP returns the slave to idle with SDA released. A START in the middle of a transaction restarts address reception.
- R12: After reset, all registers are 0x00 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe_o | output | 1 | High to pull the data line low |
| regs_o | output | NREG*8 | Register bank contents, register i at bits [8*i+7:8*i] |

## Verification
The bench builds the block with its default parameters: eight registers and device address 0x2C. With this small bank, transfers of up to ten data bytes run past the last register. That brings both pointer saturation paths within reach: discarded writes and 0xFF reads. It also lets one random write or read sweep the whole bank. A second address, 0x2D, exercises the mismatch path with the same bus timing.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } st_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } ph_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [1:0] stg_d [STAGES];
    logic [1:0] stg_q [STAGES];
    logic [1:0] prev_d, prev_q;
    logic [1:0] cur;

    always_comb begin
        stg_d[0] = {scl_i, sda_i};
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
        prev_d = stg_q[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= 2'b11;
            end
            prev_q <= 2'b11;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
            prev_q <= prev_d;
        end
    end

    assign cur        = stg_q[STAGES-1];
    assign scl_o      = cur[1];
    assign sda_o      = cur[0];
    assign scl_rise_o = cur[1] & ~prev_q[1];
    assign scl_fall_o = ~cur[1] & prev_q[1];
    assign start_o    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
    assign stop_o     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [$clog2(NREG):0] wr_idx_i,
    input  logic [DW-1:0]         wr_data_i,
    input  logic [$clog2(NREG):0] rd_idx_i,
    output logic [DW-1:0]         rd_data_o,
    output logic [NREG*DW-1:0]    regs_o
);
    localparam int IW = $clog2(NREG);
    localparam int PW = IW + 1;

    logic [DW-1:0] reg_d [NREG];
    logic [DW-1:0] reg_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            reg_d[g] = reg_q[g];
            if (wr_en_i && wr_idx_i == PW'(g)) begin
                reg_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) reg_q[g] <= '0;
            else         reg_q[g] <= reg_d[g];
        end

        assign regs_o[g*DW +: DW] = reg_q[g];
    end

    assign rd_data_o = (rd_idx_i < PW'(NREG)) ? reg_q[rd_idx_i[IW-1:0]] : '1;

    AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |-> (wr_idx_i < PW'(NREG))); // R5
endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter int         NREG     = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    output logic [NREG*BYTE_W-1:0] regs_o
);
    localparam int PW = $clog2(NREG) + 1;
    localparam logic [BYTE_W-1:0] CNT_BYTE = BYTE_W'(NREG);

    typedef struct packed {
        st_e               st;
        ph_e               ph;
        logic              rd;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [PW-1:0]     ptr;
        logic              oe;
    } ctl_t;

    ctl_t q, n;
    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic wr_en, load;
    logic [BYTE_W-1:0] rd_data, tx_byte;

    smb_line_sync #(.STAGES(2)) u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    smb_regfile #(.NREG(NREG), .DW(BYTE_W)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en),
        .wr_idx_i  (q.ptr),
        .wr_data_i (q.sh),
        .rd_idx_i  (q.ptr),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );

    assign tx_byte = (q.ph == PH_CNT) ? CNT_BYTE : rd_data;

    always_comb begin
        n     = q;
        wr_en = 1'b0;
        load  = 1'b0;
        if (stop_c) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else if (start_c) begin
            n.st  = ST_RX;
            n.ph  = PH_ADDR;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        n.cnt = '0;
                        n.st  = ST_ACK;
                        n.oe  = 1'b1;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh[7:1] == DEV_ADDR) begin
                                    n.rd  = q.sh[0];
                                    n.ptr = '0;
                                    n.ph  = q.sh[0] ? PH_CNT : PH_CMD;
                                end else begin
                                    n.st = ST_IGNORE;
                                    n.oe = 1'b0;
                                end
                            end
                            PH_CMD: begin
                                if (q.sh == '0) begin
                                    n.ph = PH_CNT;
                                end else begin
                                    n.st = ST_IGNORE;
                                    n.oe = 1'b0;
                                end
                            end
                            PH_CNT:  n.ph = PH_DATA;
                            default: begin
                                if (q.ptr < PW'(NREG)) begin
                                    wr_en = 1'b1;
                                    n.ptr = q.ptr + PW'(1);
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (q.rd) begin
                            load = 1'b1;
                        end else begin
                            n.oe  = 1'b0;
                            n.st  = ST_RX;
                            n.cnt = '0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            n.oe  = 1'b0;
                            n.st  = ST_MACK;
                            n.cnt = '0;
                        end else begin
                            n.oe  = ~q.sh[BYTE_W-1];
                            n.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                            n.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_s) n.st  = ST_IGNORE;
                        else       n.cnt = 4'd1;
                    end else if (scl_fall && q.cnt == 4'd1) begin
                        load = 1'b1;
                    end
                end
                default: ;
            endcase
            if (load) begin
                n.st  = ST_TX;
                n.oe  = ~tx_byte[BYTE_W-1];
                n.sh  = {tx_byte[BYTE_W-2:0], 1'b0};
                n.cnt = 4'd1;
                if (q.ph == PH_CNT)          n.ph  = PH_DATA;
                else if (q.ptr < PW'(NREG))  n.ptr = q.ptr + PW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, ph: PH_ADDR, rd: 1'b0, cnt: '0, sh: '0, ptr: '0, oe: 1'b0};
        end else begin
            q <= n;
        end
    end

    assign sda_oe_o = q.oe;

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.oe) |-> !$past(scl_s)); // R10
    AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(stop_c) |-> (q.st == ST_IDLE && !q.oe)); // R11
    AST_IGNORE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_IGNORE) |-> !q.oe); // R2
    AST_PTR_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.ptr <= PW'(NREG)); // R5
    AST_START_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(start_c) && !$past(stop_c)) |-> (q.st == ST_RX && q.cnt == '0)); // R11
endmodule

// File: tb/smb_blk_slave_tb.sv
`timescale 1ns/1ps
module smb_blk_slave_tb_top;
    localparam int NREG = 8;
    localparam logic [6:0] ADDR = 7'h2C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_w = sda_m & ~sda_oe;

    int vec = 0;
    int err = 0;
    logic [7:0] expr [NREG];
    logic got_ack;
    logic [7:0] got_byte;

    always #2 clk = ~clk;

    smb_blk_slave #(.DEV_ADDR(ADDR), .NREG(NREG)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_w),
        .sda_oe_o(sda_oe), .regs_o(regs)
    );

    task automatic wt(input int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec++;
        if (!ok) begin
            err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_exp(input int j);
        return (j < NREG) ? expr[j] : 8'hFF;
    endfunction

    task automatic bus_start();
        scl = 1'b0; wt(5); sda_m = 1'b1; wt(5);
        scl = 1'b1; wt(10); sda_m = 1'b0; wt(10);
    endtask

    task automatic bus_stop();
        scl = 1'b0; wt(5); sda_m = 1'b0; wt(5);
        scl = 1'b1; wt(10); sda_m = 1'b1; wt(10);
    endtask

    task automatic send(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; wt(5); sda_m = b[i]; wt(5);
            scl = 1'b1; wt(10);
        end
        scl = 1'b0; wt(5); sda_m = 1'b1; wt(5);
        scl = 1'b1; wt(5); got_ack = ~sda_w; wt(5);
    endtask

    task automatic recv(input bit ack);
        for (int i = 7; i >= 0; i--) begin
            scl = 1'b0; sda_m = 1'b1; wt(10);
            scl = 1'b1; wt(5); got_byte[i] = sda_w; wt(5);
        end
        scl = 1'b0; wt(5); sda_m = ack ? 1'b0 : 1'b1; wt(5);
        scl = 1'b1; wt(10);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++) begin
            chk(regs[i*8 +: 8] == expr[i], req, regs[i*8 +: 8], expr[i]);
        end
    endtask

    task automatic blk_write(input int nb, input logic [7:0] cntv);
        logic [7:0] b;
        bus_start();
        send({ADDR, 1'b0}); chk(got_ack, "R1 write address ack", got_ack, 1);
        send(8'h00);        chk(got_ack, "R2 zero command ack", got_ack, 1);
        send(cntv);         chk(got_ack, "R3 byte count ack", got_ack, 1);
        for (int j = 0; j < nb; j++) begin
            b = 8'($urandom);
            send(b);
            chk(got_ack, (j < NREG) ? "R4 data ack" : "R5 overflow data ack", got_ack, 1);
            if (j < NREG) expr[j] = b;
        end
        bus_stop();
        check_regs("R4 R5 R3 register contents");
    endtask

    task automatic blk_read(input int nb);
        bus_start();
        send({ADDR, 1'b0}); chk(got_ack, "R1 write address ack", got_ack, 1);
        send(8'h00);        chk(got_ack, "R9 zero command ack", got_ack, 1);
        bus_start();
        send({ADDR, 1'b1}); chk(got_ack, "R1 read address ack", got_ack, 1);
        recv(nb > 0);       chk(got_byte == 8'(NREG), "R6 count byte", got_byte, NREG);
        for (int j = 0; j < nb; j++) begin
            recv(j < nb - 1);
            chk(got_byte == rd_exp(j), (j < NREG) ? "R6 R9 read data" : "R7 read past end",
                got_byte, rd_exp(j));
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        err++; vec++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0153));
        for (int i = 0; i < NREG; i++) expr[i] = 8'h00;
        wt(5); rst_n = 1'b1; wt(5);
        // R12 reset state
        check_regs("R12 reset registers");
        chk(sda_oe == 1'b0, "R12 SDA released", sda_oe, 0);

        blk_write(8, 8'h00);   // R3 count zero yet all stored
        blk_read(8);
        blk_write(11, 8'h03);  // R5 extra bytes discarded, R3 count ignored
        blk_read(10);          // R7

        // R1 mismatching address
        bus_start();
        send({7'h2D, 1'b0}); chk(!got_ack, "R1 mismatch nack", got_ack, 0);
        send(8'h00);         chk(!got_ack, "R1 ignored after mismatch", got_ack, 0);
        send(8'h77);         chk(!got_ack, "R1 ignored after mismatch", got_ack, 0);
        bus_stop();
        check_regs("R1 registers untouched");

        // R2 nonzero command
        bus_start();
        send({ADDR, 1'b0}); chk(got_ack, "R2 address ack", got_ack, 1);
        send(8'h05);        chk(!got_ack, "R2 nonzero command nack", got_ack, 0);
        send(8'h02);        chk(!got_ack, "R2 ignored count", got_ack, 0);
        send(8'h99);        chk(!got_ack, "R2 ignored data", got_ack, 0);
        bus_stop();
        check_regs("R2 registers untouched");

        // R8 host NACK ends transmission
        bus_start();
        send({ADDR, 1'b0}); send(8'h00);
        bus_start();
        send({ADDR, 1'b1}); chk(got_ack, "R8 read address ack", got_ack, 1);
        recv(1'b1); chk(got_byte == 8'(NREG), "R8 count byte", got_byte, NREG);
        recv(1'b0); chk(got_byte == expr[0], "R8 first data", got_byte, expr[0]);
        recv(1'b0); chk(got_byte == 8'hFF, "R8 slave silent after nack", got_byte, 8'hFF);
        chk(sda_oe == 1'b0, "R8 SDA released", sda_oe, 0);
        bus_stop();

        // R11 restart mid transaction, R9 pointer reset
        bus_start();
        send({ADDR, 1'b0}); send(8'h00); send(8'h01);
        send(8'h5A); chk(got_ack, "R11 first data ack", got_ack, 1);
        bus_start();
        send({ADDR, 1'b0}); chk(got_ack, "R11 address after restart", got_ack, 1);
        send(8'h00); send(8'h01);
        send(8'hA5); chk(got_ack, "R9 data ack", got_ack, 1);
        bus_stop();
        expr[0] = 8'hA5;
        check_regs("R9 R11 restart writes register 0");

        // R11 stop in the middle then a fresh read
        bus_start();
        send({ADDR, 1'b0}); send(8'h00);
        bus_stop();
        chk(sda_oe == 1'b0, "R11 idle after stop", sda_oe, 0);
        blk_read(3);

        // Random transactions
        for (int k = 0; k < 10; k++) begin
            blk_write(int'($urandom_range(0, 10)), 8'($urandom));
            blk_read(int'($urandom_range(0, 10)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end
endmodule